// File: doc/BRIEF.md
# Two-Wire Serial Register Slave

This block is a slave on a two-wire serial bus (clock line plus open-drain data line) that gives a bus master read and write access to a small bank of 8-bit control registers. Both bus lines arrive already synchronized and deglitched. The only drive toward the bus is an enable that pulls the data line low. The device address is fixed except for its lowest bit, which comes from a strap input. Boards can therefore place two of these slaves on one bus.

A write begins with the address byte, then a subaddress byte that sets a pointer. Each later data byte is stored at the pointer, and the pointer then steps up by one. A read is a subaddress write followed by a repeated start with the read bit set. The slave then returns bytes from the pointer upward until the master declines to acknowledge. The top four registers form a 32-bit frequency word. The word driven to the core changes as a whole, only when its most significant byte is written. The full register contents are exported as a flat vector.

Top module: `ctl_i2c_regs`

## Requirements
- R1: After reset the data-line pull-down is off, every register reads 0x00 and the frequency word is 0.
- R2: The slave acknowledges only the address byte whose upper seven bits equal {6'b010101, strap_i}, with bit 0 as the read flag (1 = read). This gives 0x54/0x55 for strap 0 and 0x56/0x57 for strap 1. For any other address it does not acknowledge and ignores all bytes until the next start.
- R3: In a write, the byte after the address sets the pointer. Each following byte is stored at the pointer and acknowledged, and the pointer then increments.
- R4: A subaddress of 0x10 or above is not acknowledged. The slave goes idle and writes nothing.
- R5: A write byte that arrives after register 0x0F has been written is neither acknowledged nor stored. Later bytes of that transfer are ignored.
- R6: Read data leaves MSB first. The slave changes its data-line drive only while the clock line is low.
- R7: Auto-increment reads past 0x0F keep returning register 0x0F. A master non-acknowledge ends the read and releases the line.
- R8: freq_o equals {reg 0x0F, 0x0E, 0x0D, 0x0C} as captured at the write of 0x0F. Writes to 0x0C to 0x0E alone leave freq_o unchanged.
- R9: A stop condition at any point returns the slave to idle and discards a partial byte. A start condition at any point begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, oversamples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, synchronized |
| sda_i | input | 1 | Bus data line as seen on the wire, synchronized |
| strap_i | input | 1 | Selects the lowest device address bit |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| regs_o | output | NREG*DW (128) | All registers, register i at bits [8i+7:8i] |
| freq_o | output | FQ_LEN*DW (32) | Committed frequency word |

## Verification
The case where two functions land on one byte is a write burst that starts at 0x0E. The byte written to 0x0F both commits the frequency word and moves the pointer to the top of the map, so the very next byte meets the overflow guard. The bench drives three bytes from 0x0E and then checks three things: the acknowledge pattern is ack, ack, nack; the third byte reached no register; and freq_o took the new top byte together with the old lower bytes. Random bursts that cross the top of the map repeat this case with other data and are compared against a bench model of the map.

// File: rtl/ctl_i2c_pkg.sv
package ctl_i2c_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_SUB,
    ST_WR,
    ST_ACK,
    ST_RD,
    ST_MACK
  } bus_st_t;
endpackage

// File: rtl/ctl_i2c_line.sv
module ctl_i2c_line (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ctl_i2c_bank.sv
module ctl_i2c_bank #(
  parameter int NREG    = 16,
  parameter int DW      = 8,
  parameter int FQ_BASE = 12,
  parameter int FQ_LEN  = 4,
  localparam int AW     = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [NREG*DW-1:0]     regs_o,
  output logic [FQ_LEN*DW-1:0]   freq_o
);
  localparam int TOPI = FQ_BASE + FQ_LEN - 1;

  logic [DW-1:0]        mem [NREG];
  logic [FQ_LEN*DW-1:0] freq_q, freq_d;
  logic                 commit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem[i] <= '0;
      end else if (we_i && waddr_i == AW'(i)) begin
        mem[i] <= wdata_i;
      end
    end
    assign regs_o[i*DW +: DW] = mem[i];
  end

  // shadow bytes are the lower frequency registers themselves
  assign commit = we_i && (waddr_i == AW'(TOPI));

  always_comb begin
    freq_d = freq_q;
    if (commit) begin
      for (int k = 0; k < FQ_LEN - 1; k++) begin
        freq_d[k*DW +: DW] = mem[FQ_BASE + k];
      end
      freq_d[(FQ_LEN-1)*DW +: DW] = wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
    end else begin
      freq_q <= freq_d;
    end
  end

  assign freq_o = freq_q;

  AST_FREQ_COMMIT_ON_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_q != $past(freq_q)) |-> $past(we_i && waddr_i == AW'(TOPI))); // R8
endmodule

// File: rtl/ctl_i2c_regs.sv
module ctl_i2c_regs
  import ctl_i2c_pkg::*;
#(
  parameter int NREG          = 16,
  parameter int DW            = 8,
  parameter int FQ_BASE       = 12,
  parameter int FQ_LEN        = 4,
  parameter logic [5:0] DEV_HI = 6'b010101
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 scl_i,
  input  logic                 sda_i,
  input  logic                 strap_i,
  output logic                 sda_oe_o,
  output logic [NREG*DW-1:0]   regs_o,
  output logic [FQ_LEN*DW-1:0] freq_o
);
  localparam int AW = $clog2(NREG);
  localparam int PW = AW + 1;

  logic scl_rise, scl_fall, start_c, stop_c;

  bus_st_t       state, n_state, after, n_after;
  logic [3:0]    cnt, n_cnt;
  logic [DW-1:0] sh, n_sh;
  logic [PW-1:0] ptr, n_ptr, ptr_inc;
  logic          mack, n_mack;
  logic          we;
  logic [AW-1:0] rd_idx;
  logic [DW-1:0] rd_byte;
  logic [DW-1:0] view [NREG];

  ctl_i2c_line u_line (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_c), .stop_o(stop_c)
  );

  ctl_i2c_bank #(.NREG(NREG), .DW(DW), .FQ_BASE(FQ_BASE), .FQ_LEN(FQ_LEN)) u_bank (
    .clk(clk), .rst_n(rst_n), .we_i(we), .waddr_i(ptr[AW-1:0]),
    .wdata_i(sh), .regs_o(regs_o), .freq_o(freq_o)
  );

  for (genvar i = 0; i < NREG; i++) begin : g_view
    assign view[i] = regs_o[i*DW +: DW];
  end

  // reads beyond the map stay on the highest register
  assign rd_idx  = (ptr >= PW'(NREG)) ? AW'(NREG - 1) : ptr[AW-1:0];
  assign rd_byte = view[rd_idx];
  assign ptr_inc = (ptr >= PW'(NREG)) ? ptr : ptr + 1'b1;

  always_comb begin
    n_state = state;
    n_after = after;
    n_cnt   = cnt;
    n_sh    = sh;
    n_ptr   = ptr;
    n_mack  = mack;
    we      = 1'b0;
    if (stop_c) begin
      n_state = ST_IDLE;
    end else if (start_c) begin
      n_state = ST_ADDR;
      n_cnt   = '0;
    end else begin
      unique case (state)
        ST_ADDR, ST_SUB, ST_WR: begin
          if (scl_rise) begin
            n_sh  = {sh[DW-2:0], sda_i};
            n_cnt = cnt + 1'b1;
          end else if (scl_fall && cnt == 4'(DW)) begin
            n_cnt   = '0;
            n_state = ST_IDLE;
            if (state == ST_ADDR) begin
              if (sh[7:1] == {DEV_HI, strap_i}) begin
                n_state = ST_ACK;
                n_after = sh[0] ? ST_RD : ST_SUB;
              end
            end else if (state == ST_SUB) begin
              if (sh < DW'(NREG)) begin
                n_ptr   = PW'(sh[AW-1:0]);
                n_state = ST_ACK;
                n_after = ST_WR;
              end
            end else begin
              if (ptr < PW'(NREG)) begin
                we      = 1'b1;
                n_ptr   = ptr_inc;
                n_state = ST_ACK;
                n_after = ST_WR;
              end
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            n_state = after;
            n_cnt   = '0;
            if (after == ST_RD) begin
              n_sh  = rd_byte;
              n_ptr = ptr_inc;
            end
          end
        end
        ST_RD: begin
          if (scl_fall) begin
            if (cnt == 4'(DW - 1)) begin
              n_state = ST_MACK;
              n_cnt   = '0;
            end else begin
              n_sh  = {sh[DW-2:0], 1'b0};
              n_cnt = cnt + 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            n_mack = ~sda_i;
          end else if (scl_fall) begin
            if (mack) begin
              n_state = ST_RD;
              n_sh    = rd_byte;
              n_ptr   = ptr_inc;
            end else begin
              n_state = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      after <= ST_IDLE;
      cnt   <= '0;
      sh    <= '0;
      ptr   <= '0;
      mack  <= 1'b0;
    end else begin
      state <= n_state;
      after <= n_after;
      cnt   <= n_cnt;
      sh    <= n_sh;
      ptr   <= n_ptr;
      mack  <= n_mack;
    end
  end

  assign sda_oe_o = (state == ST_ACK) || (state == ST_RD && !sh[DW-1]);

  AST_DRIVE_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe_o != $past(sda_oe_o)) |-> !$past(scl_i)); // R6
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> state == ST_IDLE); // R9
  AST_NO_ACK_PAST_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WR && ptr == PW'(NREG)) |-> !sda_oe_o); // R5
  AST_PTR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= PW'(NREG)); // R7
  AST_START_TO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (start_c && !stop_c) |=> state == ST_ADDR); // R9
endmodule

// File: tb/sim_ctl_i2c_regs.sv
module sim_ctl_i2c_regs;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1, strap = 1'b0;
  logic sda_oe, sda_bus;
  logic [127:0] regs;
  logic [31:0]  freq;

  int checks = 0, errors = 0, viol = 0;
  bit done = 1'b0;
  logic [7:0] mem [16];
  logic [31:0] mfreq;

  always #2.5 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  ctl_i2c_regs u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .strap_i(strap),
    .sda_oe_o(sda_oe), .regs_o(regs), .freq_o(freq)
  );

  // R6: drive may only move while the clock line is low
  logic p_oe = 1'b0, p_scl = 1'b1;
  always @(negedge clk) begin
    if (rst_n && sda_oe != p_oe && m_scl && p_scl) viol++;
    p_oe  <= sda_oe;
    p_scl <= m_scl;
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bstart();
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic bstop();
    m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
  endtask

  task automatic sbit(input logic b);
    m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q);
  endtask

  task automatic sbyte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) sbit(b[i]);
    m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q/2);
    ack = !sda_bus;
    wt(Q/2); m_scl = 1'b0; wt(Q);
  endtask

  task automatic rbyte(input bit nack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wt(Q); m_scl = 1'b1; wt(Q); b = {b[6:0], sda_bus}; m_scl = 1'b0;
    end
    m_sda = nack; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0; wt(Q); m_sda = 1'b1;
  endtask

  function automatic logic [7:0] rg(input int i);
    return regs[i*8 +: 8];
  endfunction

  function automatic logic [7:0] exp_rd(input int idx);
    return (idx > 15) ? mem[15] : mem[idx];
  endfunction

  function automatic logic [7:0] waddr();
    return {6'b010101, strap, 1'b0};
  endfunction

  // write n bytes from sub, checking acks against the map model
  task automatic wburst(input int sub, input int n, input logic [7:0] d [8]);
    bit a;
    bstart();
    sbyte(waddr(), a); chk("R2 addr ack", 32'(a), 1);
    sbyte(8'(sub), a); chk("R3 sub ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      sbyte(d[k], a);
      chk((sub + k < 16) ? "R3 data ack" : "R5 overflow nack", 32'(a), (sub + k < 16) ? 1 : 0);
      if (sub + k < 16) begin
        mem[sub + k] = d[k];
        if (sub + k == 15) mfreq = {d[k], mem[14], mem[13], mem[12]};
      end
    end
    bstop();
  endtask

  task automatic rburst(input int sub, input int n);
    bit a;
    logic [7:0] b;
    bstart();
    sbyte(waddr(), a);
    sbyte(8'(sub), a);
    bstart();
    sbyte(waddr() | 8'h01, a); chk("R6 read addr ack", 32'(a), 1);
    for (int k = 0; k < n; k++) begin
      rbyte(k == n - 1, b);
      chk((sub + k > 15) ? "R7 read past top" : "R6 read data", 32'(b), 32'(exp_rd(sub + k)));
    end
    chk("R7 released after nack", 32'(sda_oe), 0);
    bstop();
  endtask

  task automatic chk_map(input string req);
    for (int i = 0; i < 16; i++) chk(req, 32'(rg(i)), 32'(mem[i]));
    chk(req, freq, mfreq);
  endtask

  initial begin
    bit a;
    logic [7:0] d [8];
    int unsigned seed;
    seed = $urandom(32'd4242);
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;
    mfreq = '0;
    wt(3);
    chk("R1 oe at reset", 32'(sda_oe), 0);
    chk("R1 regs at reset", regs[31:0] | regs[63:32] | regs[95:64] | regs[127:96], 0);
    chk("R1 freq at reset", freq, 0);
    rst_n = 1'b1;
    wt(4);

    // R2: wrong address ignored, including the bytes that follow
    bstart();
    sbyte(8'h56, a); chk("R2 0x56 nack strap0", 32'(a), 0);
    sbyte(8'h01, a); chk("R2 ignored sub", 32'(a), 0);
    sbyte(8'hAA, a); chk("R2 ignored data", 32'(a), 0);
    bstop();
    chk_map("R2 map untouched");
    strap = 1'b1; wt(2);
    bstart(); sbyte(8'h56, a); chk("R2 0x56 ack strap1", 32'(a), 1); bstop();
    bstart(); sbyte(8'h54, a); chk("R2 0x54 nack strap1", 32'(a), 0); bstop();
    strap = 1'b0; wt(2);

    // R3: plain auto-increment write
    d = '{8'hAA, 8'hBB, 8'hCC, 0, 0, 0, 0, 0};
    wburst(3, 3, d);
    chk_map("R3 write burst");

    // R4: invalid subaddress
    bstart();
    sbyte(waddr(), a);
    sbyte(8'h10, a); chk("R4 bad sub nack", 32'(a), 0);
    sbyte(8'h77, a); chk("R4 data ignored", 32'(a), 0);
    bstop();
    chk_map("R4 map untouched");

    // R5 and R8 together: commit and overflow on neighbouring bytes
    d = '{8'h11, 8'h22, 8'h33, 0, 0, 0, 0, 0};
    wburst(14, 3, d);
    chk_map("R5 R8 top of map");
    chk("R8 freq top commit", freq, 32'h2211_0000);

    // R8: lower bytes alone do not commit
    d = '{8'h01, 8'h02, 8'h03, 0, 0, 0, 0, 0};
    wburst(12, 3, d);
    chk("R8 freq held", freq, 32'h2211_0000);
    d = '{8'h04, 0, 0, 0, 0, 0, 0, 0};
    wburst(15, 1, d);
    chk("R8 freq committed", freq, 32'h0403_0201);

    // R7: reads past top repeat 0x0F
    rburst(13, 5);

    // R9: stop mid-byte discards the partial byte
    bstart(); sbyte(waddr(), a); sbyte(8'h05, a);
    sbit(1); sbit(0); sbit(1); sbit(1);
    bstop();
    chk("R9 stop mid byte", 32'(rg(5)), 32'(mem[5]));
    // R9: start mid-byte begins a new address phase
    bstart(); sbyte(waddr(), a); sbyte(8'h06, a);
    sbit(1); sbit(1); sbit(0);
    bstart();
    sbyte(waddr(), a); chk("R9 restart addr ack", 32'(a), 1);
    sbyte(8'h06, a);
    sbyte(8'h5A, a); chk("R9 restart data ack", 32'(a), 1);
    bstop();
    mem[6] = 8'h5A;
    chk("R9 restart write", 32'(rg(6)), 32'h5A);

    // random bursts against the model
    for (int r = 0; r < 24; r++) begin
      int sub, n;
      sub = int'($urandom_range(0, 15));
      n = int'($urandom_range(1, 6));
      if (sub + n > 17) n = 17 - sub;
      for (int k = 0; k < 8; k++) d[k] = 8'($urandom());
      wburst(sub, n, d);
      chk("R8 random freq", freq, mfreq);
      rburst(int'($urandom_range(0, 15)), int'($urandom_range(1, 5)));
    end
    chk_map("R3 final map");
    chk("R6 drive only with clock low", viol, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule